// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This block runs the byte exchange of an SPI master. When software asks for an exchange, the engine takes bytes one at a time from a transmit FIFO and shifts each one out on the data-out line, most significant bit first. At the same time it shifts in one byte from the data-in line. Each received byte is either written to a receive FIFO or dropped. Both FIFOs sit outside the block. The transmit FIFO presents its head byte with its empty flag, and the receive FIFO presents its full flag.

Two limits set how long an exchange runs. The burst length is the total number of bytes to exchange. The exchange stops as soon as that many bytes have gone out, or as soon as the transmit FIFO has no more data, whichever happens first. The skip length applies only when the drop-leading mode is on. In that mode the first skip-length received bytes are thrown away, so that the kept bytes start after a command phase. Both limits are copied into internal counters when the exchange starts and are never written back.

The serial clock runs at the system clock divided by twice the DIV parameter. A polarity input sets its idle level, and a phase input picks which edge samples data. The engine raises `busy` for the whole exchange and pulses `done` once at the end.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, `busy`, `done`, `tx_pop`, `rx_push` and `rx_lost` are 0, and `sclk` equals `cpol`.
- R2: A one-cycle `start` while idle begins an exchange. Each transmit byte is popped with a single-cycle `tx_pop` and sent MSB first on `mosi`. Each byte takes exactly 16 `sclk` transitions.
- R3: Each received byte is assembled MSB first from `miso` and placed on `rx_byte` with a one-cycle `rx_push`. Kept bytes are pushed in the order they were received.
- R4: `sclk` rests at `cpol` whenever the engine is idle. With `cpha`=0, `mosi` holds the bit before the first edge, data is sampled on leading edges and changes on trailing edges. With `cpha`=1, data changes on leading edges and is sampled on trailing edges.
- R5: After `burst_len` bytes the exchange ends, even if transmit data remains. Any bytes left stay in the transmit FIFO for the next exchange. A `burst_len` of 0 sets no limit below 2^CNT_W bytes.
- R6: When `drop_lead` is 1, the first `skip_len` received bytes of the exchange produce neither `rx_push` nor `rx_lost`. When `drop_lead` is 0, `skip_len` has no effect.
- R7: A byte that should be kept while `rx_full` is 1 is discarded with a one-cycle `rx_lost` pulse and no `rx_push`.
- R8: If the exchange starts with the transmit FIFO empty, `done` is high after the second rising edge following `start`, and `sclk` does not move.
- R9: Within a byte, successive `sclk` transitions are exactly DIV system clocks apart.
- R10: `done` is a single-cycle pulse, asserted in the same cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Exchange request pulse; ignored while busy |
| drop_lead | input | 1 | Enables dropping of the leading received bytes |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sampling edge select (0 leading, 1 trailing) |
| burst_len | input | CNT_W | Bytes to exchange; 0 means no limit |
| skip_len | input | CNT_W | Leading received bytes to drop when `drop_lead` is 1 |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_pop | output | 1 | Consumes the transmit FIFO head byte |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_push | output | 1 | Writes `rx_byte` into the receive FIFO |
| rx_byte | output | 8 | Received byte |
| rx_lost | output | 1 | A kept byte was discarded because the receive FIFO was full |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange finished pulse |

## Verification
Three kinds of internal fault show up quickly at the ports. A shifter with a wrong edge index or phase decode changes the number of `sclk` transitions in a byte, or the bits that a bus-side slave model captures and returns. This is visible within one byte time, about 16·DIV clocks. A burst or skip counter loaded or decremented wrongly shows up as extra or missing `tx_pop`, `rx_push` or `rx_lost` pulses, and as bytes left in the transmit FIFO model when `done` arrives. A controller that leaves its idle state by mistake is caught in the cycle it happens, by a `done` that does not line up with `busy` falling, or by an `sclk` away from `cpol` while idle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int BYTE_W = 8;
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SHIFT = 2'd2
    } eng_st_e;

    typedef struct packed {
        logic              active;
        logic [EDGE_W-1:0] edge_n;
        logic [BYTE_W-1:0] tx_sr;
        logic [BYTE_W-1:0] rx_sr;
        logic              lvl;
        logic              done;
    } shf_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    shf_t s_d, s_q;
    logic lead, samp, shft;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        lead     = ~s_q.edge_n[0];
        samp     = lead ^ cpha;
        shft     = cpha ? (lead && s_q.edge_n != '0) : (!lead && s_q.edge_n != LAST_EDGE);
        if (load) begin
            s_d.active = 1'b1;
            s_d.edge_n = '0;
            s_d.tx_sr  = load_byte;
            s_d.lvl    = 1'b0;
        end else if (s_q.active && tick) begin
            if (samp) s_d.rx_sr = {s_q.rx_sr[BYTE_W-2:0], miso};
            if (shft) s_d.tx_sr = {s_q.tx_sr[BYTE_W-2:0], 1'b0};
            s_d.lvl = ~s_q.lvl;
            if (s_q.edge_n == LAST_EDGE) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
            end else begin
                s_d.edge_n = s_q.edge_n + EDGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk      = cpol ^ s_q.lvl;
    assign mosi      = s_q.tx_sr[BYTE_W-1];
    assign active    = s_q.active;
    assign byte_done = s_q.done;
    assign rx_byte   = s_q.rx_sr;
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int DIV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              drop_lead,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  skip_len,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_lost,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  bc;
        logic [CNT_W-1:0]  tc;
        logic              done;
        logic              push;
        logic              lost;
        logic [BYTE_W-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;
    logic load, tick, sh_active, sh_done, keep;
    logic [BYTE_W-1:0] sh_rx;
    logic [CNT_W-1:0]  bc_dec;

    assign load = (c_q.st == ST_CHECK) && !tx_empty;

    spi_half_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (sh_active),
        .tick (tick)
    );

    spi_byte_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_byte(tx_data),
        .tick     (tick),
        .cpol     (cpol),
        .cpha     (cpha),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .active   (sh_active),
        .byte_done(sh_done),
        .rx_byte  (sh_rx)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.push = 1'b0;
        c_d.lost = 1'b0;
        keep     = !(drop_lead && c_q.tc != '0);
        bc_dec   = c_q.bc - CNT_W'(1);
        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st = ST_CHECK;
                    c_d.bc = burst_len;
                    c_d.tc = skip_len;
                end
            end
            ST_CHECK: begin
                if (tx_empty) begin
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                end else begin
                    c_d.st = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (!keep)       c_d.tc = c_q.tc - CNT_W'(1);
                    else if (rx_full) c_d.lost = 1'b1;
                    else begin
                        c_d.push  = 1'b1;
                        c_d.rdata = sh_rx;
                    end
                    c_d.bc = bc_dec;
                    if (bc_dec == '0) begin
                        c_d.done = 1'b1;
                        c_d.st   = ST_IDLE;
                    end else begin
                        c_d.st = ST_CHECK;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign tx_pop  = load;
    assign rx_push = c_q.push;
    assign rx_byte = c_q.rdata;
    assign rx_lost = c_q.lost;
    assign busy    = (c_q.st != ST_IDLE);
    assign done    = c_q.done;
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cpol,
    input logic tx_empty,
    input logic tx_pop,
    input logic rx_push,
    input logic rx_lost,
    input logic sclk,
    input logic busy,
    input logic done
);
    AST_POP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (busy && !tx_empty)); // R2
    AST_POP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop); // R2
    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol)); // R4
    AST_PUSH_XOR_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_push && rx_lost)); // R7
    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && tx_empty) |=> done); // R8
    AST_DONE_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10
    AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R10
    AST_IDLE_NO_START_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy); // R2
endmodule

bind spi_burst_engine spi_burst_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cpol    (cpol),
    .tx_empty(tx_empty),
    .tx_pop  (tx_pop),
    .rx_push (rx_push),
    .rx_lost (rx_lost),
    .sclk    (sclk),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;
    localparam int PERIOD = 10;
    localparam int CNT_W  = 24;
    localparam int DIV    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, drop_lead = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic [CNT_W-1:0] burst_len = '0, skip_len = '0;
    logic [7:0] tx_data, rx_byte;
    logic tx_empty, tx_pop, rx_full = 1'b0, rx_push, rx_lost;
    logic sclk, mosi, miso, busy, done;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    spi_burst_engine #(.CNT_W(CNT_W), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .drop_lead(drop_lead),
        .cpol(cpol), .cpha(cpha), .burst_len(burst_len), .skip_len(skip_len),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte), .rx_lost(rx_lost),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy), .done(done)
    );

    // transmit FIFO model
    logic [7:0] txm [0:15];
    int tx_head = 0, tx_tail = 0;
    assign tx_data  = txm[tx_head % 16];
    assign tx_empty = (tx_tail == tx_head);
    always @(posedge clk) if (tx_pop) tx_head <= tx_head + 1;

    // receive FIFO model
    logic [7:0] rxm [0:63];
    int rx_cnt = 0, lost_cnt = 0;
    always @(posedge clk) begin
        if (rx_push) begin rxm[rx_cnt % 64] <= rx_byte; rx_cnt <= rx_cnt + 1; end
        if (rx_lost) lost_cnt <= lost_cnt + 1;
    end

    function automatic logic [7:0] resp(input int k);
        return 8'hC5 + 8'(29 * k);
    endfunction

    // bus-side slave model
    logic [7:0] s_tx = 8'hC5, s_rx = 8'h00;
    logic [7:0] cap [0:63];
    int s_bits = 0, ncap = 0, nedge = 0, good_gap = 0, bad_gap = 0;
    time last_t = 0;
    assign miso = s_tx[7];
    always @(sclk) begin : slave
        logic lead;
        if (busy) begin
            nedge = nedge + 1;
            if ($time - last_t == DIV * PERIOD) good_gap = good_gap + 1;
            else if ($time - last_t < DIV * PERIOD) bad_gap = bad_gap + 1;
            last_t = $time;
            lead = (sclk != cpol);
            if (lead ^ cpha) begin
                s_rx = {s_rx[6:0], mosi};
                s_bits = s_bits + 1;
                if (s_bits == 8) begin
                    cap[ncap % 64] = s_rx;
                    ncap = ncap + 1;
                    s_tx = resp(ncap);
                    s_bits = 0;
                end
            end else if (s_bits != 0) begin
                s_tx = {s_tx[6:0], 1'b0};
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        txm[tx_tail % 16] = b;
        tx_tail++;
    endtask

    task automatic run_xfer(input int bc, input int tc, input bit disc);
        int n;
        @(negedge clk);
        burst_len = CNT_W'(bc); skip_len = CNT_W'(tc); drop_lead = disc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, "R10 exchange end seen", 32'(n), 32'd0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", {busy, done}, 0);
        chk(tx_pop == 1'b0 && rx_push == 1'b0 && rx_lost == 1'b0, "R1 strobes after reset",
            {tx_pop, rx_push, rx_lost}, 0);
        chk(sclk == cpol, "R1 sclk idle", 32'(sclk), 32'(cpol));
    endtask

    task automatic t_mode(input bit cp, input bit ch);
        int cb, rb, eb, gb;
        @(negedge clk);
        cpol = cp; cpha = ch;
        @(negedge clk);
        chk(sclk == cp, "R4 idle level", 32'(sclk), 32'(cp));
        cb = ncap; rb = rx_cnt; eb = nedge; gb = good_gap;
        for (int i = 0; i < 3; i++) push_tx((8'h5A + 8'(17 * i)) ^ {cp, ch, 6'd0});
        run_xfer(3, 0, 1'b0);
        chk(ncap - cb == 3, "R2 bytes sent", 32'(ncap - cb), 3);
        for (int i = 0; i < 3; i++) begin
            chk(cap[(cb + i) % 64] == ((8'h5A + 8'(17 * i)) ^ {cp, ch, 6'd0}), "R2 mosi byte MSB first",
                cap[(cb + i) % 64], (8'h5A + 8'(17 * i)) ^ {cp, ch, 6'd0});
            chk(rxm[(rb + i) % 64] == resp(cb + i), "R3 received byte",
                rxm[(rb + i) % 64], resp(cb + i));
        end
        chk(rx_cnt - rb == 3, "R3 push count", 32'(rx_cnt - rb), 3);
        chk(nedge - eb == 48, "R2 sclk transitions", 32'(nedge - eb), 48);
        chk(good_gap - gb == 45, "R9 half period spacing", 32'(good_gap - gb), 45);
        chk(bad_gap == 0, "R9 short half period", 32'(bad_gap), 0);
        chk(sclk == cp, "R4 level after exchange", 32'(sclk), 32'(cp));
        chk(tx_empty, "R2 fifo drained", 32'(tx_tail - tx_head), 0);
    endtask

    task automatic t_burst;
        int cb;
        cb = ncap;
        for (int i = 0; i < 4; i++) push_tx(8'h10 + 8'(i));
        run_xfer(2, 0, 1'b0);
        chk(ncap - cb == 2, "R5 burst limit stops", 32'(ncap - cb), 2);
        chk(tx_tail - tx_head == 2, "R5 remaining tx bytes", 32'(tx_tail - tx_head), 2);
        run_xfer(0, 0, 1'b0);
        chk(ncap - cb == 4, "R5 zero burst runs to empty", 32'(ncap - cb), 4);
        chk(cap[(cb + 2) % 64] == 8'h12 && cap[(cb + 3) % 64] == 8'h13, "R5 leftover order",
            {cap[(cb + 2) % 64], cap[(cb + 3) % 64]}, 16'h1213);
    endtask

    task automatic t_discard;
        int cb, rb;
        cb = ncap; rb = rx_cnt;
        for (int i = 0; i < 4; i++) push_tx(8'hE0 + 8'(i));
        run_xfer(0, 2, 1'b1);
        chk(rx_cnt - rb == 2, "R6 dropped leading bytes", 32'(rx_cnt - rb), 2);
        chk(rxm[rb % 64] == resp(cb + 2), "R6 first kept byte", rxm[rb % 64], resp(cb + 2));
        chk(rxm[(rb + 1) % 64] == resp(cb + 3), "R6 second kept byte", rxm[(rb + 1) % 64], resp(cb + 3));
        cb = ncap; rb = rx_cnt;
        for (int i = 0; i < 4; i++) push_tx(8'hF0 + 8'(i));
        run_xfer(0, 2, 1'b0);
        chk(rx_cnt - rb == 4, "R6 skip length ignored when off", 32'(rx_cnt - rb), 4);
        chk(rxm[rb % 64] == resp(cb), "R6 first byte kept when off", rxm[rb % 64], resp(cb));
    endtask

    task automatic t_full;
        int rb, lb, cb;
        rb = rx_cnt; lb = lost_cnt; cb = ncap;
        rx_full = 1'b1;
        push_tx(8'h33); push_tx(8'h44);
        run_xfer(0, 0, 1'b0);
        rx_full = 1'b0;
        chk(rx_cnt - rb == 0, "R7 no push when full", 32'(rx_cnt - rb), 0);
        chk(lost_cnt - lb == 2, "R7 lost pulses", 32'(lost_cnt - lb), 2);
        chk(ncap - cb == 2, "R7 bytes still sent", 32'(ncap - cb), 2);
    endtask

    task automatic t_empty;
        int eb;
        eb = nedge;
        @(negedge clk);
        burst_len = CNT_W'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R8 first cycle", {busy, done}, 2'b10);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R8 done second edge", {busy, done}, 2'b01);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", 32'(done), 0);
        chk(nedge == eb && sclk == cpol, "R8 no clock activity", 32'(nedge - eb), 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mode(1'b0, 1'b0);
        t_mode(1'b0, 1'b1);
        t_mode(1'b1, 1'b0);
        t_mode(1'b1, 1'b1);
        t_burst();
        t_discard();
        t_full();
        t_empty();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule